// File: doc/BRIEF.md
# Multi-tank pump priority controller

This block runs the water transfer from one main reservoir to four roof tanks, A, B, C and F. It reads three marks on the reservoir and two marks on each roof tank. It drives three lamps that show the reservoir level and one pump enable per roof tank. A roof tank that drops below its low mark asks for water. The controller grants one request at a time, in a fixed priority order. The granted pump runs until that tank reaches its refill mark. Because the start and stop marks differ, each tank fills with hysteresis.

The arbiter never pre-empts a fill. A tank that dips low while another tank is filling is remembered, and it is served once the current fill ends. Whenever the reservoir is at its dead level, all pumping is inhibited. Any pump that is running stops on the next clock edge. Pending requests stay latched and are arbitrated again when water returns. Sensor inputs are assumed to be clean levels that are synchronous to the clock. The tank count is a parameter, and the default is four.

Top module: `pump_priority_ctrl`

## Requirements
- R1: The lamps are registered and reflect the reservoir inputs sampled at the previous clock edge. The lamp inputs are res_full, res_half and res_dead.
  - lamp_red is on when res_dead=1.
  - lamp_yellow is on when res_half=1 and res_dead=0.
  - lamp_green is on when res_full=1, res_half=0 and res_dead=0.
  - Otherwise no lamp is lit, so at most one lamp is ever on.
- R2: Bit i of tank_low, tank_top and pump_en belongs to one tank: bit 0 is A, bit 1 is B, bit 2 is C and bit 3 is F. Suppose the controller is idle with no pump on, the reservoir is not at its dead level, and tank_low[i]=1 at a clock edge. Then a pump enable is asserted after that same edge.
- R3: A granted pump keeps running after its tank_low bit returns to 0. It stops on the first clock edge at which its tank_top bit is 1.
- R4: At most one bit of pump_en is ever 1. After one fill ends, pump_en is all zero for at least one cycle before the next pump starts.
- R5: Among the tanks requesting at an arbitration, the lowest bit index wins, giving the order A, B, C, F. After a fill ends, the next waiting tank is granted one edge after the idle cycle.
- R6: A running fill is not pre-empted. A request from a higher-priority tank does not change pump_en until the current fill ends.
- R7: A tank_low pulse of a single cycle is latched. It is served after the current fill ends, or once pumping is allowed again.
- R8: While res_dead=1 no pump starts. If res_dead becomes 1 during a fill, pump_en goes to zero on the next edge. That tank's request stays pending, so its fill resumes once res_dead returns to 0.
- R9: A synchronous active-high rst turns all pumps and lamps off and clears every pending request, so no fill follows the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_full | input | 1 | Reservoir at its almost-full mark |
| res_half | input | 1 | Reservoir at its half mark |
| res_dead | input | 1 | Reservoir at or below its dead level |
| tank_low | input | NUM_TANKS | Roof tank below its low mark, bit 0 = A |
| tank_top | input | NUM_TANKS | Roof tank at its refill mark, bit 0 = A |
| lamp_green | output | 1 | Almost-full lamp |
| lamp_yellow | output | 1 | Half-level lamp |
| lamp_red | output | 1 | Dead-level danger lamp |
| pump_en | output | NUM_TANKS | One-hot pump enables, bit 0 = A |

## Verification
Every output is registered, so both the lamps and a pump start or stop are due one clock edge after the inputs that cause them. The bench drives inputs on the falling edge and samples them on the next falling edge, which means exactly one rising edge lies in between. When one fill hands over to the next, the bench first checks the idle cycle after the tank_top edge. It then expects the next grant one edge later. Checks for no pre-emption and for the dead-level hold sample over several further cycles, to confirm that nothing changes.

// File: rtl/pump_ctl_pkg.sv
package pump_ctl_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_FILL = 1'b1
   } fill_state_t;

   localparam int MAX_TANKS = 16;

endpackage

// File: rtl/reservoir_lamps.sv
module reservoir_lamps (
   input  logic clk,
   input  logic rst,
   input  logic full_in,
   input  logic half_in,
   input  logic dead_in,
   output logic green_q,
   output logic yellow_q,
   output logic red_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         green_q  <= 1'b0;
         yellow_q <= 1'b0;
         red_q    <= 1'b0;
      end else begin
         red_q    <= dead_in;
         yellow_q <= half_in & ~dead_in;
         green_q  <= full_in & ~half_in & ~dead_in;
      end
   end

   assert_lamp_exclusive_R1 : assert property (@(posedge clk) disable iff (rst)
      $onehot0({green_q, yellow_q, red_q}));

   assert_red_wins_R1 : assert property (@(posedge clk) disable iff (rst)
      dead_in |=> (red_q && !yellow_q && !green_q));

endmodule

// File: rtl/request_bank.sv
module request_bank #(
   parameter int NUM_TANKS = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_TANKS-1:0] low_in,
   input  logic [NUM_TANKS-1:0] clr_in,
   output logic [NUM_TANKS-1:0] req_out
);

   logic [NUM_TANKS-1:0] pend_q;

   for (genvar i = 0; i < NUM_TANKS; i++) begin : g_tank
      always_ff @(posedge clk) begin
         if (rst)
            pend_q[i] <= 1'b0;
         else if (clr_in[i])
            pend_q[i] <= 1'b0;
         else if (low_in[i])
            pend_q[i] <= 1'b1;
      end

      assign req_out[i] = pend_q[i] | low_in[i];

      assert_req_latched_R7 : assert property (@(posedge clk) disable iff (rst)
         (low_in[i] && !clr_in[i]) |=> pend_q[i]);

      assert_req_cleared_R3 : assert property (@(posedge clk) disable iff (rst)
         clr_in[i] |=> !pend_q[i]);
   end

endmodule

// File: rtl/priority_pick.sv
module priority_pick #(
   parameter int NUM_TANKS = 4
) (
   input  logic [NUM_TANKS-1:0] req_in,
   output logic [NUM_TANKS-1:0] grant_oh,
   output logic                 any_req
);

   logic [NUM_TANKS:0] seen;

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < NUM_TANKS; i++) begin : g_chain
      assign grant_oh[i]  = req_in[i] & ~seen[i];
      assign seen[i+1]    = seen[i] | req_in[i];
   end

   assign any_req = seen[NUM_TANKS];

   always_comb begin
      assert_grant_onehot_R5 : assert ($onehot0(grant_oh));
   end

endmodule

// File: rtl/pump_fsm.sv
module pump_fsm
   import pump_ctl_pkg::*;
#(
   parameter int NUM_TANKS = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 dead_in,
   input  logic                 any_req,
   input  logic [NUM_TANKS-1:0] grant_oh,
   input  logic [NUM_TANKS-1:0] top_in,
   output logic [NUM_TANKS-1:0] done_out,
   output logic [NUM_TANKS-1:0] pump_out
);

   localparam logic [NUM_TANKS-1:0] NONE = '0;

   fill_state_t          state_q;
   logic [NUM_TANKS-1:0] owner_q;
   logic                 owner_full;

   assign owner_full = (owner_q & top_in) != NONE;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         owner_q <= NONE;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (any_req && !dead_in) begin
                  state_q <= ST_FILL;
                  owner_q <= grant_oh;
               end
            end
            ST_FILL: begin
               if (dead_in || owner_full) begin
                  state_q <= ST_IDLE;
                  owner_q <= NONE;
               end
            end
            default: begin
               state_q <= ST_IDLE;
               owner_q <= NONE;
            end
         endcase
      end
   end

   assign done_out = (state_q == ST_FILL) ? (owner_q & top_in) : NONE;
   assign pump_out = (state_q == ST_FILL) ? owner_q : NONE;

   assert_single_pump_R4 : assert property (@(posedge clk) disable iff (rst)
      $onehot0(pump_out));

   assert_gap_after_fill_R4 : assert property (@(posedge clk) disable iff (rst)
      (pump_out != NONE && (pump_out & top_in) != NONE) |=> pump_out == NONE);

   assert_no_preempt_R6 : assert property (@(posedge clk) disable iff (rst)
      (pump_out != NONE && !dead_in && (pump_out & top_in) == NONE)
      |=> pump_out == $past(pump_out));

   assert_dead_stops_R8 : assert property (@(posedge clk) disable iff (rst)
      dead_in |=> pump_out == NONE);

   assert_idle_grants_R2 : assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_IDLE && any_req && !dead_in) |=> pump_out != NONE);

endmodule

// File: rtl/pump_priority_ctrl.sv
module pump_priority_ctrl
   import pump_ctl_pkg::*;
#(
   parameter int NUM_TANKS = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 res_full,
   input  logic                 res_half,
   input  logic                 res_dead,
   input  logic [NUM_TANKS-1:0] tank_low,
   input  logic [NUM_TANKS-1:0] tank_top,
   output logic                 lamp_green,
   output logic                 lamp_yellow,
   output logic                 lamp_red,
   output logic [NUM_TANKS-1:0] pump_en
);

   if (NUM_TANKS < 1 || NUM_TANKS > MAX_TANKS) begin : g_bad_cfg
      $error("pump_priority_ctrl: NUM_TANKS out of range");
   end

   logic [NUM_TANKS-1:0] req_w;
   logic [NUM_TANKS-1:0] grant_w;
   logic [NUM_TANKS-1:0] done_w;
   logic                 any_w;

   reservoir_lamps u_lamps (
      .clk      (clk),
      .rst      (rst),
      .full_in  (res_full),
      .half_in  (res_half),
      .dead_in  (res_dead),
      .green_q  (lamp_green),
      .yellow_q (lamp_yellow),
      .red_q    (lamp_red)
   );

   request_bank #(.NUM_TANKS(NUM_TANKS)) u_reqs (
      .clk     (clk),
      .rst     (rst),
      .low_in  (tank_low),
      .clr_in  (done_w),
      .req_out (req_w)
   );

   priority_pick #(.NUM_TANKS(NUM_TANKS)) u_pick (
      .req_in   (req_w),
      .grant_oh (grant_w),
      .any_req  (any_w)
   );

   pump_fsm #(.NUM_TANKS(NUM_TANKS)) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .dead_in  (res_dead),
      .any_req  (any_w),
      .grant_oh (grant_w),
      .top_in   (tank_top),
      .done_out (done_w),
      .pump_out (pump_en)
   );

endmodule

// File: tb/pump_priority_ctrl_test.sv
module pump_priority_ctrl_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       res_full = 1'b0;
   logic       res_half = 1'b0;
   logic       res_dead = 1'b0;
   logic [3:0] tank_low = 4'h0;
   logic [3:0] tank_top = 4'h0;
   logic       lamp_green;
   logic       lamp_yellow;
   logic       lamp_red;
   logic [3:0] pump_en;

   int total = 0;
   int bad   = 0;

   // {full, half, dead, green, yellow, red}
   localparam logic [5:0] LAMP_VEC [0:7] = '{
      6'b000_000, 6'b100_100, 6'b010_010, 6'b110_010,
      6'b001_001, 6'b101_001, 6'b011_001, 6'b111_001
   };

   always #2 clk = ~clk;

   pump_priority_ctrl #(.NUM_TANKS(4)) uut (
      .clk         (clk),
      .rst         (rst),
      .res_full    (res_full),
      .res_half    (res_half),
      .res_dead    (res_dead),
      .tank_low    (tank_low),
      .tank_top    (tank_top),
      .lamp_green  (lamp_green),
      .lamp_yellow (lamp_yellow),
      .lamp_red    (lamp_red),
      .pump_en     (pump_en)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic check_pump(input string tag, input logic [3:0] exp);
      check(tag, {4'h0, pump_en}, {4'h0, exp});
      check("R4 onehot", {7'd0, ($countones(pump_en) > 1)}, 8'h00);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R9 reset state with requests and a lamp input present
      rst = 1'b1; tank_low = 4'hF; res_full = 1'b1;
      tick(2);
      check_pump("R9 pumps in reset", 4'h0);
      check("R9 lamps in reset", {5'd0, lamp_green, lamp_yellow, lamp_red}, 8'h00);
      rst = 1'b0; tank_low = 4'h0; res_full = 1'b0;
      tick(1);
      check_pump("R9 no pending after reset", 4'h0);
      tick(1);
      check_pump("R9 still idle", 4'h0);

      // R1 lamp table
      for (int k = 0; k < 8; k++) begin
         {res_full, res_half, res_dead} = LAMP_VEC[k][5:3];
         tick(1);
         check("R1 lamps", {5'd0, lamp_green, lamp_yellow, lamp_red},
               {5'd0, LAMP_VEC[k][2:0]});
      end
      {res_full, res_half, res_dead} = 3'b000;
      tick(1);

      // R2/R3 single tank B with hysteresis
      tank_low = 4'b0010;
      tick(1);
      check_pump("R2 start B", 4'b0010);
      tank_low = 4'h0;
      tick(3);
      check_pump("R3 hysteresis hold", 4'b0010);
      tank_top = 4'b0010;
      tick(1);
      check_pump("R3 stop at top", 4'h0);
      tank_top = 4'h0;
      tick(1);
      check_pump("R3 stays off", 4'h0);

      // R5 all four at once, served A,B,C,F with R4 gaps
      tank_low = 4'hF;
      tick(1);
      check_pump("R5 A first", 4'b0001);
      tank_low = 4'h0;
      for (int i = 0; i < 4; i++) begin
         tank_top = 4'(1 << i);
         tick(1);
         check_pump("R4 idle gap", 4'h0);
         tank_top = 4'h0;
         tick(1);
         check_pump("R5 next in order", (i < 3) ? 4'(1 << (i + 1)) : 4'h0);
      end

      // R6 no pre-emption, R7 latched request served afterwards
      tank_low = 4'b0100;
      tick(1);
      check_pump("R2 start C", 4'b0100);
      tank_low = 4'b0001;
      tick(1);
      tank_low = 4'h0;
      check_pump("R6 C keeps pump", 4'b0100);
      tick(2);
      check_pump("R6 C still running", 4'b0100);
      tank_top = 4'b0100;
      tick(1);
      tank_top = 4'h0;
      check_pump("R4 gap after C", 4'h0);
      tick(1);
      check_pump("R7 latched A served", 4'b0001);
      tank_top = 4'b0001;
      tick(1);
      tank_top = 4'h0;
      check_pump("R3 A done", 4'h0);
      tick(1);
      check_pump("R7 nothing left", 4'h0);

      // R8 dead level during a fill
      tank_low = 4'b0001;
      tick(1);
      check_pump("R2 start A", 4'b0001);
      tank_low = 4'h0; res_dead = 1'b1;
      tick(1);
      check_pump("R8 dead stops pump", 4'h0);
      tick(3);
      check_pump("R8 held off while dead", 4'h0);
      res_dead = 1'b0;
      tick(1);
      check_pump("R8 resume A", 4'b0001);
      tank_top = 4'b0001;
      tick(1);
      tank_top = 4'h0;
      check_pump("R3 A done again", 4'h0);

      // R8/R7 request arriving while dead
      res_dead = 1'b1; tank_low = 4'b1000;
      tick(1);
      tank_low = 4'h0;
      check_pump("R8 no start while dead", 4'h0);
      tick(2);
      check_pump("R8 still no start", 4'h0);
      res_dead = 1'b0;
      tick(1);
      check_pump("R7 F served after dead", 4'b1000);
      tank_top = 4'b1000;
      tick(1);
      tank_top = 4'h0;
      check_pump("R3 F done", 4'h0);

      // R9 reset during a fill clears it and its request
      tank_low = 4'b0001;
      tick(1);
      check_pump("R2 start A before reset", 4'b0001);
      rst = 1'b1; tank_low = 4'h0;
      tick(1);
      check_pump("R9 reset stops pump", 4'h0);
      rst = 1'b0;
      tick(2);
      check_pump("R9 request cleared", 4'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule